// File: doc/BRIEF.md
# Banked Window Bus Bridge

This block lets an 8-bit secondary processor reach a 32 KB window of a 16-bit main bus. Each secondary access with the top address bit set (0x8000 to 0xFFFF) is carried across the bridge. Every lower address belongs to the secondary side's local memory and never reaches the main bus. For a bridged access, the bridge holds the secondary processor in wait. It asks the main-bus arbiter for ownership and waits for the grant. It then runs one main-bus cycle, hands read data back on the 8-bit bus, and gives the bus up again.

A 9-bit window register forms main address bits 23:15. Secondary address bits 14:1 form the word address, and bit 0 picks the byte lane. The bridge keeps the bus only for the single access that needs it. When another master, such as a DMA engine, owns the bus, the bridge does not raise its request and the secondary processor stays stalled. The address strobe has an output enable as well as a level. The bridge leaves the strobe undriven for a cycle on each side of its own drive window, so that control passes cleanly between masters. If no acknowledge arrives, a timeout ends the cycle.

The secondary side holds `sec_req`, the address and the write data steady until it sees `sec_wait` low. It then drops `sec_req` for at least one cycle before it starts the next access.

Top module: `win_bridge`

## Requirements
- R1: A request with `sec_addr[15]`=0 never asserts `sec_wait` or `mb_req`.
- R2: A bridged request (`sec_req`=1, `sec_addr[15]`=1) asserts `mb_req` one cycle after decode, as long as `mb_busy` is low.
- R3: `mb_as_oe` is high only while `mb_grant` is high. At least one cycle with the grant high and `mb_as_oe` low comes before the strobe is driven.
- R4: Each bridged access performs exactly one acknowledged main-bus cycle. `mb_addr[23:1]` = {window register, `sec_addr[14:1]`}, and `mb_rw` is 1 for a read and 0 for a write.
- R5: An even address selects the upper byte (bits 15:8), with `mb_uds_n`=0 and `mb_lds_n`=1. An odd address selects the lower byte (bits 7:0), with `mb_lds_n`=0 and `mb_uds_n`=1. A read returns the selected byte. A write places the byte on both halves of `mb_wdata`.
- R6: `sec_wait` is high from decode of a bridged request until `sec_rdata` is valid or the write is acknowledged. With grant one cycle after request and acknowledge one cycle after the strobe, `sec_wait` falls on the sixth clock edge after the request.
- R7: In the cycle after completion, `mb_req` and `mb_as_oe` are low. They stay low until the next bridged request, so back-to-back accesses each raise `mb_req` separately.
- R8: If `mb_dtack_n` stays high for TIMEOUT cycles of driven strobe, the access ends with read data 0xFF and the bus is released. `sec_wait` then falls on clock edge 4+TIMEOUT after the request.
- R9: `win_we`=1 loads `win_din` into the window register at the next clock edge. The register resets to 0.
- R10: While `mb_busy` is high, `mb_req` does not rise and `sec_wait` stays high. The access proceeds once `mb_busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_req | input | 1 | Secondary memory request, held for the access |
| sec_wr | input | 1 | 1 = write, 0 = read |
| sec_addr | input | 16 | Secondary address |
| sec_wdata | input | 8 | Secondary write data |
| sec_rdata | output | 8 | Read data returned to the secondary side |
| sec_wait | output | 1 | Wait request to the secondary processor |
| win_we | input | 1 | Window register load strobe |
| win_din | input | 9 | Window register load value |
| mb_busy | input | 1 | Another master currently owns the main bus |
| mb_req | output | 1 | Bus request to the arbiter |
| mb_grant | input | 1 | Bus grant from the arbiter |
| mb_addr | output | 23 | Main word address, bits 23:1 |
| mb_as_oe | output | 1 | Address strobe drive enable |
| mb_as_n | output | 1 | Address strobe, active low |
| mb_rw | output | 1 | 1 = read, 0 = write |
| mb_uds_n | output | 1 | Upper byte strobe, active low |
| mb_lds_n | output | 1 | Lower byte strobe, active low |
| mb_wdata | output | 16 | Main write data |
| mb_data_oe | output | 1 | Main data drive enable |
| mb_rdata | input | 16 | Main read data |
| mb_dtack_n | input | 1 | Data acknowledge, active low |

## Verification
On every cycle, the assertions check that the strobe is driven only under grant and after a one-cycle guard, and that no request rises while another master holds the bus. They also check that the request is dropped once the secondary side is released, that local addresses never stall, that the timeout counter stays in range, and that the window register loads. Only the bench scenarios can show the rest. These are the exact wait length of a normal or timed-out access, byte-lane steering and data returned for even and odd addresses, the composed main address after a window change, exactly one bus cycle per access, and a stall that lasts for the whole of a DMA tenure. The bench's arbiter and DMA model also show that the two masters never drive the strobe together.

// File: rtl/win_bridge_pkg.sv
package win_bridge_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_GAP  = 3'd2,
    ST_ACC  = 3'd3,
    ST_DONE = 3'd4
  } wb_state_e;

  localparam logic [7:0] TIMEOUT_BYTE = 8'hFF;
endpackage

// File: rtl/win_reg.sv
module win_reg #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nx;

  always_comb begin
    q_nx = q;
    if (we) q_nx = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nx;
  end

  a_r9_window_load: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q == $past(din)));
endmodule

// File: rtl/win_datapath.sv
module win_datapath
  import win_bridge_pkg::*;
#(
  parameter int BANK_W = 9,
  parameter int SEC_AW = 16,
  parameter int DW     = 8,
  localparam int MAW   = BANK_W + SEC_AW - 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BANK_W-1:0] bank,
  input  logic [SEC_AW-1:0] sec_addr,
  input  logic [DW-1:0]   sec_wdata,
  input  logic            drive,
  input  logic            cap_en,
  input  logic            cap_to,
  input  logic [2*DW-1:0] mb_rdata,
  output logic [MAW-1:0]  mb_addr,
  output logic            mb_uds_n,
  output logic            mb_lds_n,
  output logic [2*DW-1:0] mb_wdata,
  output logic [DW-1:0]   sec_rdata
);
  logic          lane_lo;
  logic [DW-1:0] pick;
  logic [DW-1:0] rd_nx;

  assign lane_lo  = sec_addr[0];
  assign mb_addr  = {bank, sec_addr[SEC_AW-2:1]};
  assign mb_uds_n = !(drive && !lane_lo);
  assign mb_lds_n = !(drive && lane_lo);
  assign mb_wdata = {sec_wdata, sec_wdata};
  assign pick     = lane_lo ? mb_rdata[DW-1:0] : mb_rdata[2*DW-1:DW];

  always_comb begin
    rd_nx = sec_rdata;
    if (cap_en)      rd_nx = pick;
    else if (cap_to) rd_nx = TIMEOUT_BYTE[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sec_rdata <= '0;
    else        sec_rdata <= rd_nx;
  end
endmodule

// File: rtl/win_ctrl.sv
module win_ctrl
  import win_bridge_pkg::*;
#(
  parameter int TIMEOUT = 16,
  localparam int TW     = $clog2(TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bridged,
  input  logic mb_busy,
  input  logic mb_grant,
  input  logic mb_dtack_n,
  output logic mb_req,
  output logic drive,
  output logic cap_en,
  output logic cap_to,
  output logic sec_wait
);
  wb_state_e st, st_nx;
  logic [TW-1:0] tmr, tmr_nx;
  logic expired;

  assign expired = (tmr == TW'(TIMEOUT - 1));

  always_comb begin
    st_nx  = st;
    tmr_nx = tmr;
    case (st)
      ST_IDLE: if (bridged && !mb_busy) st_nx = ST_REQ;
      ST_REQ:  if (mb_grant) st_nx = ST_GAP;
      ST_GAP:  begin st_nx = ST_ACC; tmr_nx = '0; end
      ST_ACC: begin
        if (!mb_dtack_n || expired) st_nx = ST_DONE;
        else tmr_nx = tmr + 1'b1;
      end
      ST_DONE: if (!bridged) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      tmr <= '0;
    end else begin
      st  <= st_nx;
      tmr <= tmr_nx;
    end
  end

  assign mb_req   = (st == ST_REQ) || (st == ST_GAP) || (st == ST_ACC);
  assign drive    = (st == ST_ACC);
  assign cap_en   = drive && !mb_dtack_n;
  assign cap_to   = drive && mb_dtack_n && expired;
  assign sec_wait = bridged && (st != ST_DONE);

  a_r3_drive_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    drive |-> mb_grant);
  a_r3_guard_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive) |-> $past(mb_grant));
  a_r10_no_req_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mb_req) |-> !$past(mb_busy));
  a_r7_release_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (bridged && !sec_wait) |-> (!mb_req && !drive));
  a_r8_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tmr < TW'(TIMEOUT));
endmodule

// File: rtl/win_bridge.sv
module win_bridge #(
  parameter int BANK_W  = 9,
  parameter int SEC_AW  = 16,
  parameter int DW      = 8,
  parameter int TIMEOUT = 16,
  localparam int MAW    = BANK_W + SEC_AW - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_req,
  input  logic              sec_wr,
  input  logic [SEC_AW-1:0] sec_addr,
  input  logic [DW-1:0]     sec_wdata,
  output logic [DW-1:0]     sec_rdata,
  output logic              sec_wait,
  input  logic              win_we,
  input  logic [BANK_W-1:0] win_din,
  input  logic              mb_busy,
  output logic              mb_req,
  input  logic              mb_grant,
  output logic [MAW-1:0]    mb_addr,
  output logic              mb_as_oe,
  output logic              mb_as_n,
  output logic              mb_rw,
  output logic              mb_uds_n,
  output logic              mb_lds_n,
  output logic [2*DW-1:0]   mb_wdata,
  output logic              mb_data_oe,
  input  logic [2*DW-1:0]   mb_rdata,
  input  logic              mb_dtack_n
);
  logic [1:0] rst_pipe;
  logic rst_s_n;
  logic [BANK_W-1:0] bank;
  logic bridged, drive, cap_en, cap_to;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  assign bridged = sec_req && sec_addr[SEC_AW-1];

  win_reg #(.W(BANK_W)) u_win (
    .clk(clk), .rst_n(rst_s_n), .we(win_we), .din(win_din), .q(bank)
  );

  win_ctrl #(.TIMEOUT(TIMEOUT)) u_ctrl (
    .clk(clk), .rst_n(rst_s_n), .bridged(bridged), .mb_busy(mb_busy),
    .mb_grant(mb_grant), .mb_dtack_n(mb_dtack_n), .mb_req(mb_req),
    .drive(drive), .cap_en(cap_en), .cap_to(cap_to), .sec_wait(sec_wait)
  );

  win_datapath #(.BANK_W(BANK_W), .SEC_AW(SEC_AW), .DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_s_n), .bank(bank), .sec_addr(sec_addr),
    .sec_wdata(sec_wdata), .drive(drive), .cap_en(cap_en), .cap_to(cap_to),
    .mb_rdata(mb_rdata), .mb_addr(mb_addr), .mb_uds_n(mb_uds_n),
    .mb_lds_n(mb_lds_n), .mb_wdata(mb_wdata), .sec_rdata(sec_rdata)
  );

  assign mb_as_oe   = drive;
  assign mb_as_n    = !drive;
  assign mb_rw      = !sec_wr;
  assign mb_data_oe = drive && sec_wr;

  a_r1_local_no_stall: assert property (@(posedge clk) disable iff (!rst_s_n)
    (sec_req && !sec_addr[SEC_AW-1]) |-> (!sec_wait && !mb_req));
endmodule

// File: tb/win_bridge_test.sv
module win_bridge_test;
  localparam int CLK_PERIOD = 10;
  localparam int TO = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_req = 1'b0, sec_wr = 1'b0;
  logic [15:0] sec_addr = '0;
  logic [7:0] sec_wdata = '0;
  logic [7:0] sec_rdata;
  logic sec_wait;
  logic win_we = 1'b0;
  logic [8:0] win_din = '0;
  logic mb_req, mb_grant;
  logic [23:1] mb_addr;
  logic mb_as_oe, mb_as_n, mb_rw, mb_uds_n, mb_lds_n, mb_data_oe;
  logic [15:0] mb_wdata, mb_rdata;
  logic mb_dtack_n;

  // environment models
  logic dma_own = 1'b0, dma_drive = 1'b0, tgt_en = 1'b1;
  logic grant_q, dtack_q;
  int tests = 0, fails = 0;
  int acc_cnt = 0, req_rises = 0;
  logic [23:1] last_addr;
  logic [15:0] last_wdata;
  logic last_uds_n, last_lds_n, last_rw, prev_req;
  logic [7:0] rd_res;
  int n_res;

  always #(CLK_PERIOD/2) clk = ~clk;

  win_bridge #(.TIMEOUT(TO)) uut (
    .clk(clk), .rst_n(rst_n), .sec_req(sec_req), .sec_wr(sec_wr),
    .sec_addr(sec_addr), .sec_wdata(sec_wdata), .sec_rdata(sec_rdata),
    .sec_wait(sec_wait), .win_we(win_we), .win_din(win_din),
    .mb_busy(dma_own), .mb_req(mb_req), .mb_grant(mb_grant),
    .mb_addr(mb_addr), .mb_as_oe(mb_as_oe), .mb_as_n(mb_as_n), .mb_rw(mb_rw),
    .mb_uds_n(mb_uds_n), .mb_lds_n(mb_lds_n), .mb_wdata(mb_wdata),
    .mb_data_oe(mb_data_oe), .mb_rdata(mb_rdata), .mb_dtack_n(mb_dtack_n)
  );

  function automatic logic [15:0] word_of(input logic [23:1] a);
    return {a[8:1], ~a[8:1]};
  endfunction

  assign mb_rdata   = word_of(mb_addr);
  assign mb_grant   = grant_q;
  assign mb_dtack_n = dtack_q;

  // arbiter and target, behavioural
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= 1'b0; dtack_q <= 1'b1; prev_req <= 1'b0;
    end else begin
      grant_q  <= mb_req && !dma_own;
      dtack_q  <= !(mb_as_oe && !mb_as_n && tgt_en);
      prev_req <= mb_req;
      if (mb_req && !prev_req) req_rises <= req_rises + 1;
      if (mb_as_oe && !mb_as_n && !mb_dtack_n) begin
        acc_cnt    <= acc_cnt + 1;
        last_addr  <= mb_addr;
        last_wdata <= mb_wdata;
        last_uds_n <= mb_uds_n;
        last_lds_n <= mb_lds_n;
        last_rw    <= mb_rw;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparisons against the environment model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 strobe contention", {31'd0, mb_as_oe && dma_drive}, 32'd0);
      if (mb_as_oe) chk("R3 drive without grant", {31'd0, mb_grant}, 32'd1);
      if (dma_own && !mb_grant) chk("R10 request while busy", {31'd0, mb_req}, 32'd0);
      if (sec_req && !sec_addr[15]) chk("R1 local stall", {30'd0, sec_wait, mb_req}, 32'd0);
    end
  end

  task automatic access(input logic wr, input logic [15:0] a, input logic [7:0] wd);
    int n = 0;
    @(negedge clk);
    sec_req = 1'b1; sec_wr = wr; sec_addr = a; sec_wdata = wd;
    do begin
      @(posedge clk); @(negedge clk); n++;
    end while (sec_wait && n < 1000);
    rd_res = sec_rdata; n_res = n;
    sec_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_up;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6 reset wait", {31'd0, sec_wait}, 32'd0);
    chk("R7 reset req", {30'd0, mb_req, mb_as_oe}, 32'd0);
    chk("R9 reset window", {9'd0, mb_addr}, 32'd0);

    // R1: local address
    sec_req = 1'b1; sec_addr = 16'h1234;
    repeat (4) @(negedge clk);
    chk("R1 local wait", {31'd0, sec_wait}, 32'd0);
    chk("R1 local req rises", req_rises, 0);
    sec_req = 1'b0;

    // R2 R4 R5 R6: even read
    access(1'b0, 16'h8024, 8'h00);
    chk("R6 read latency", n_res, 6);
    chk("R5 even read byte", rd_res, 8'h12);
    chk("R4 even read addr", {9'd0, last_addr}, {9'd0, 9'd0, 14'h0012});
    chk("R5 even lanes", {30'd0, last_uds_n, last_lds_n}, 32'b01);
    chk("R4 read rw", {31'd0, last_rw}, 32'd1);
    chk("R2 one request", req_rises, 1);
    chk("R7 released", {30'd0, mb_req, mb_as_oe}, 32'd0);

    // R5: odd read
    access(1'b0, 16'h8025, 8'h00);
    chk("R5 odd read byte", rd_res, 8'hED);
    chk("R5 odd lanes", {30'd0, last_uds_n, last_lds_n}, 32'b10);

    // R9 R4: window change then write
    @(negedge clk); win_we = 1'b1; win_din = 9'h1A5;
    @(negedge clk); win_we = 1'b0;
    base = acc_cnt;
    access(1'b1, 16'hC3F0, 8'h5C);
    chk("R4 one bus cycle", acc_cnt - base, 1);
    chk("R9 window high bits", {23'd0, last_addr[23:15]}, 32'h1A5);
    chk("R4 write low addr", {18'd0, last_addr[14:1]}, 32'h21F8);
    chk("R4 write rw", {31'd0, last_rw}, 32'd0);
    chk("R5 write data", {16'd0, last_wdata}, 32'h5C5C);
    chk("R5 write even lanes", {30'd0, last_uds_n, last_lds_n}, 32'b01);
    chk("R6 write latency", n_res, 6);

    // R7: back-to-back accesses raise request separately
    base = req_rises;
    access(1'b0, 16'h8002, 8'h00);
    access(1'b0, 16'h8003, 8'h00);
    chk("R7 separate requests", req_rises - base, 2);
    chk("R7 idle after pair", {30'd0, mb_req, mb_as_oe}, 32'd0);

    // R10: DMA holds the bus
    @(negedge clk); dma_own = 1'b1;
    @(negedge clk); dma_drive = 1'b1;
    fork
      access(1'b0, 16'h8010, 8'h00);
      begin
        repeat (12) @(negedge clk);
        chk("R10 stalled wait", {31'd0, sec_wait}, 32'd1);
        chk("R10 no request", {31'd0, mb_req}, 32'd0);
        dma_drive = 1'b0;
        @(negedge clk); dma_own = 1'b0;
      end
    join
    chk("R10 data after stall", rd_res, 8'h08);
    chk("R10 stall length", {31'd0, n_res > 12}, 32'd1);

    // R8: no acknowledge
    tgt_en = 1'b0;
    base = acc_cnt;
    access(1'b0, 16'h8040, 8'h00);
    chk("R8 timeout data", rd_res, 8'hFF);
    chk("R8 timeout latency", n_res, 4 + TO);
    chk("R8 bus released", {30'd0, mb_req, mb_as_oe}, 32'd0);
    chk("R8 no acknowledged cycle", acc_cnt - base, 0);
    tgt_en = 1'b1;

    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule